// File: doc/BRIEF.md
# Shared-Memory Byte Ring Port

This block moves bytes in and out of a circular byte buffer that is kept in another processor's memory. It reaches that memory only through a simple single-transaction master port. The buffer's bookkeeping also lives in that memory, in three bytes placed directly below the data area: a size mask, the producer's write index and the consumer's read index. A configuration input gives the base address of the data area. A base of zero turns the port off.

An init handshake latches the base and copies the three header bytes into local registers. After that, a client can issue status queries, pops and pushes, each through its own valid/ready pair. Each check for empty or full re-reads the other side's index from memory, so a partner processor can change it at any time. A pop or push may be non-blocking, which gives up at once if the ring is empty or full. It may instead be blocking, which keeps polling memory until there is room or data. When several requests are pending, the order is init, then status, then pop, then push.

Top module: `srb_port`

## Requirements
- R1: An init with a nonzero base performs exactly three reads, in the order base-3 (size mask), base-2 (write index), base-1 (read index), and the values read become the local mask, write index and read index.
- R2: Zero base (including the state after reset, before any init) disables the port: status answers empty=1 and full=0, every pop answers rd_hit=0, every push answers wr_taken=0 (blocking or not), and no memory transaction is issued.
- R3: A status query reads the write index at base-2. It reports st_empty=1 exactly when that fresh value equals the local read index.
- R4: A status query reads the read index at base-1. It reports st_full=1 exactly when (local write index + 1) AND mask equals that fresh value.
- R5: A successful pop performs three transactions: a read of base-2, a read of base+read index (returned on rd_data with rd_hit=1), and a write of (read index + 1) AND mask to base-1. That last value becomes the new local read index.
- R6: A successful push performs three transactions: a read of base-1, a write of wr_data to base+write index, and a write of (write index + 1) AND mask to base-2. That last value becomes the new local write index, and wr_taken=1.
- R7: A non-blocking pop (rd_block=0) on an empty ring answers rd_hit=0 after the single check read and writes nothing.
- R8: A non-blocking push (wr_block=0) on a full ring answers wr_taken=0 after the single check read and writes nothing.
- R9: A blocking pop on an empty ring re-reads base-2 repeatedly and gives no answer until the fresh write index differs from the local read index. It then completes as in R5.
- R10: A blocking push on a full ring re-reads base-1 repeatedly and gives no answer until the ring is no longer full. It then completes as in R6.
- R11: At most one memory transaction is open at a time. mem_req, mem_we, mem_addr and mem_wdata hold steady until mem_ack, and mem_req is low for at least the cycle after an acknowledged transaction.
- R12: Each ready output is a one-cycle pulse that answers a valid that was high in the previous cycle, and at most one ready is high in any cycle. When several valids are pending, init is served before status, status before pop, and pop before push.
- R13: Header and data addresses are computed modulo 2^ADDR_W, so a base of 1 puts the header at the top two addresses and at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_base | input | ADDR_W | Base address of the data area; zero disables. Held stable during init |
| init_valid | input | 1 | Request to (re)load the base and header |
| init_ready | output | 1 | Init finished |
| st_valid | input | 1 | Request for empty/full status |
| st_ready | output | 1 | Status answer valid |
| st_empty | output | 1 | Ring empty (valid with st_ready) |
| st_full | output | 1 | Ring full (valid with st_ready) |
| rd_valid | input | 1 | Pop request |
| rd_block | input | 1 | 1: wait for data, 0: give up if empty |
| rd_ready | output | 1 | Pop finished |
| rd_hit | output | 1 | A byte was delivered |
| rd_data | output | DATA_W | Popped byte |
| wr_valid | input | 1 | Push request |
| wr_block | input | 1 | 1: wait for room, 0: give up if full |
| wr_data | input | DATA_W | Byte to push, stable while wr_valid |
| wr_ready | output | 1 | Push finished |
| wr_taken | output | 1 | The byte was stored |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1: write, 0: read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Transaction acknowledge; read data valid in this cycle |
| mem_rdata | input | DATA_W | Read data |

## Verification
The bench builds the port with ADDR_W=8 and DATA_W=8, so the whole 256-byte memory can be modelled and every address can be logged and checked, including the wrap below address 0. The header holds a size mask of 7. Three fill-and-drain rounds, each started from a different index and run with 0, 1 and 2 wait states, move the indices through every position of the ring and reach both the full and the empty boundary. With a memory this small, blocking polls, partner-side index changes and the disabled state are short enough to observe transaction by transaction.

// File: rtl/srb_pkg.sv
// Shared definitions for the shared-memory byte ring port.
// Assumes the ring header sits directly below the data base address.
package srb_pkg;

    // Header byte distances below the data base address
    localparam int OFS_MASK = 3;
    localparam int OFS_WI   = 2;
    localparam int OFS_RI   = 1;

    // Slots of the two local index registers
    localparam int IX_WR  = 0;
    localparam int IX_RD  = 1;
    localparam int N_IDX  = 2;

    typedef enum logic [3:0] {
        S_IDLE,
        S_INI_MASK,
        S_INI_WI,
        S_INI_RI,
        S_ST_WI,
        S_ST_RI,
        S_POP_CHK,
        S_POP_DAT,
        S_POP_WB,
        S_PSH_CHK,
        S_PSH_DAT,
        S_PSH_WB,
        S_RESP
    } srb_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_INIT,
        OP_STAT,
        OP_POP,
        OP_PUSH
    } srb_op_e;

endpackage

// File: rtl/srb_mem_seq.sv
// Memory master for single transactions.
// Latches one transaction on a go pulse and holds it on the bus until acknowledged.
// Assumes go is only raised while no transaction is open.
module srb_mem_seq #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              go_we,
    input  logic [ADDR_W-1:0] go_addr,
    input  logic [DATA_W-1:0] go_wdata,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack
);

    logic              req_q;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    // Open a transaction on go, close it on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (req_q) begin
            if (mem_ack) req_q <= 1'b0;
        end else if (go) begin
            req_q   <= 1'b1;
            we_q    <= go_we;
            addr_q  <= go_addr;
            wdata_q <= go_wdata;
        end
    end

    assign done      = req_q && mem_ack;
    assign mem_req   = req_q;
    assign mem_we    = we_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;

endmodule

// File: rtl/srb_idx_reg.sv
// One local ring index: loaded from memory or stepped by one, wrapped by the mask.
// Assumes the mask has the form 2^k-1.
module srb_idx_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         adv,
    input  logic [W-1:0] mask,
    output logic [W-1:0] q,
    output logic [W-1:0] nxt
);

    assign nxt = (q + W'(1)) & mask;

    // Hold, load or advance the index
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (ld)  q <= ld_val;
        else if (adv) q <= nxt;
    end

endmodule

// File: rtl/srb_ring_regs.sv
// Local copies of the ring header: the size mask and both indices.
// Assumes load and advance strobes of one slot never coincide.
module srb_ring_regs
    import srb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ld_mask,
    input  logic [N_IDX-1:0]              ld_idx,
    input  logic [N_IDX-1:0]              adv_idx,
    input  logic [DATA_W-1:0]             ld_val,
    output logic [N_IDX-1:0][DATA_W-1:0]  idx_q,
    output logic [N_IDX-1:0][DATA_W-1:0]  idx_nxt
);

    logic [DATA_W-1:0] mask_q;

    // Hold the size mask read at init
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (ld_mask) mask_q <= ld_val;
    end

    for (genvar i = 0; i < N_IDX; i++) begin : g_idx
        srb_idx_reg #(.W(DATA_W)) u_idx (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (ld_idx[i]),
            .ld_val (ld_val),
            .adv    (adv_idx[i]),
            .mask   (mask_q),
            .q      (idx_q[i]),
            .nxt    (idx_nxt[i])
        );
    end

endmodule

// File: rtl/srb_ctrl.sv
// Sequencer of the ring port: arbitrates requests, walks the memory
// steps of init, status, pop and push, and produces the answers.
// Assumes requesters hold valid and their inputs steady until ready.
module srb_ctrl
    import srb_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             cfg_base,
    input  logic                          init_valid,
    output logic                          init_ready,
    input  logic                          st_valid,
    output logic                          st_ready,
    output logic                          st_empty,
    output logic                          st_full,
    input  logic                          rd_valid,
    input  logic                          rd_block,
    output logic                          rd_ready,
    output logic                          rd_hit,
    output logic [DATA_W-1:0]             rd_data,
    input  logic                          wr_valid,
    input  logic                          wr_block,
    input  logic [DATA_W-1:0]             wr_data,
    output logic                          wr_ready,
    output logic                          wr_taken,
    output logic                          go,
    output logic                          go_we,
    output logic [ADDR_W-1:0]             go_addr,
    output logic [DATA_W-1:0]             go_wdata,
    input  logic                          done,
    input  logic [DATA_W-1:0]             rdata,
    output logic                          ld_mask,
    output logic [N_IDX-1:0]              ld_idx,
    output logic [N_IDX-1:0]              adv_idx,
    input  logic [N_IDX-1:0][DATA_W-1:0]  idx_q,
    input  logic [N_IDX-1:0][DATA_W-1:0]  idx_nxt
);

    srb_state_e        state_q;
    srb_op_e           op_q;
    logic              issued_q;
    logic              blk_q;
    logic              en_q;
    logic [ADDR_W-1:0] base_q;
    logic [DATA_W-1:0] wdat_q;
    logic [DATA_W-1:0] res_data_q;
    logic              res_hit_q;
    logic              empty_q;
    logic              full_q;

    logic              mem_state;
    logic              fresh_eq_rd;
    logic              fresh_eq_wr_nxt;
    logic [ADDR_W-1:0] a_mask, a_wi, a_ri, a_rdat, a_wdat;

    assign a_mask = base_q - ADDR_W'(OFS_MASK);
    assign a_wi   = base_q - ADDR_W'(OFS_WI);
    assign a_ri   = base_q - ADDR_W'(OFS_RI);
    assign a_rdat = base_q + ADDR_W'(idx_q[IX_RD]);
    assign a_wdat = base_q + ADDR_W'(idx_q[IX_WR]);

    // Compare a fresh remote index with the local ones
    assign fresh_eq_rd     = (rdata == idx_q[IX_RD]);
    assign fresh_eq_wr_nxt = (rdata == idx_nxt[IX_WR]);

    assign mem_state = (state_q != S_IDLE) && (state_q != S_RESP);
    assign go        = mem_state && !issued_q;

    // Select address, direction and data of the current memory step
    always_comb begin
        go_we    = 1'b0;
        go_addr  = a_ri;
        go_wdata = '0;
        case (state_q)
            S_INI_MASK:                  go_addr = a_mask;
            S_INI_WI, S_ST_WI, S_POP_CHK: go_addr = a_wi;
            S_INI_RI, S_ST_RI, S_PSH_CHK: go_addr = a_ri;
            S_POP_DAT:                   go_addr = a_rdat;
            S_POP_WB: begin
                go_addr  = a_ri;
                go_we    = 1'b1;
                go_wdata = idx_nxt[IX_RD];
            end
            S_PSH_DAT: begin
                go_addr  = a_wdat;
                go_we    = 1'b1;
                go_wdata = wdat_q;
            end
            S_PSH_WB: begin
                go_addr  = a_wi;
                go_we    = 1'b1;
                go_wdata = idx_nxt[IX_WR];
            end
            default: ;
        endcase
    end

    // Strobe header loads and index steps on completed memory steps
    always_comb begin
        ld_mask          = done && (state_q == S_INI_MASK);
        ld_idx           = '0;
        adv_idx          = '0;
        ld_idx[IX_WR]    = done && (state_q == S_INI_WI);
        ld_idx[IX_RD]    = done && (state_q == S_INI_RI);
        adv_idx[IX_RD]   = done && (state_q == S_POP_WB);
        adv_idx[IX_WR]   = done && (state_q == S_PSH_WB);
    end

    // Main sequencer: arbitration, step order and answer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            op_q       <= OP_NONE;
            issued_q   <= 1'b0;
            blk_q      <= 1'b0;
            en_q       <= 1'b0;
            base_q     <= '0;
            wdat_q     <= '0;
            res_data_q <= '0;
            res_hit_q  <= 1'b0;
            empty_q    <= 1'b1;
            full_q     <= 1'b0;
        end else begin
            if (go)   issued_q <= 1'b1;
            if (done) issued_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    res_hit_q <= 1'b0;
                    if (init_valid) begin
                        op_q   <= OP_INIT;
                        base_q <= cfg_base;
                        en_q   <= (cfg_base != '0);
                        state_q <= (cfg_base != '0) ? S_INI_MASK : S_RESP;
                    end else if (st_valid) begin
                        op_q <= OP_STAT;
                        if (en_q) state_q <= S_ST_WI;
                        else begin
                            empty_q <= 1'b1;
                            full_q  <= 1'b0;
                            state_q <= S_RESP;
                        end
                    end else if (rd_valid) begin
                        op_q    <= OP_POP;
                        blk_q   <= rd_block;
                        state_q <= en_q ? S_POP_CHK : S_RESP;
                    end else if (wr_valid) begin
                        op_q    <= OP_PUSH;
                        blk_q   <= wr_block;
                        wdat_q  <= wr_data;
                        state_q <= en_q ? S_PSH_CHK : S_RESP;
                    end
                end
                S_INI_MASK: if (done) state_q <= S_INI_WI;
                S_INI_WI:   if (done) state_q <= S_INI_RI;
                S_INI_RI:   if (done) state_q <= S_RESP;
                S_ST_WI: if (done) begin
                    empty_q <= fresh_eq_rd;
                    state_q <= S_ST_RI;
                end
                S_ST_RI: if (done) begin
                    full_q  <= fresh_eq_wr_nxt;
                    state_q <= S_RESP;
                end
                S_POP_CHK: if (done) begin
                    if (!fresh_eq_rd) state_q <= S_POP_DAT;
                    else if (!blk_q)  state_q <= S_RESP;
                end
                S_POP_DAT: if (done) begin
                    res_data_q <= rdata;
                    state_q    <= S_POP_WB;
                end
                S_POP_WB: if (done) begin
                    res_hit_q <= 1'b1;
                    state_q   <= S_RESP;
                end
                S_PSH_CHK: if (done) begin
                    if (!fresh_eq_wr_nxt) state_q <= S_PSH_DAT;
                    else if (!blk_q)      state_q <= S_RESP;
                end
                S_PSH_DAT: if (done) state_q <= S_PSH_WB;
                S_PSH_WB: if (done) begin
                    res_hit_q <= 1'b1;
                    state_q   <= S_RESP;
                end
                S_RESP: begin
                    op_q    <= OP_NONE;
                    state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign init_ready = (state_q == S_RESP) && (op_q == OP_INIT);
    assign st_ready   = (state_q == S_RESP) && (op_q == OP_STAT);
    assign rd_ready   = (state_q == S_RESP) && (op_q == OP_POP);
    assign wr_ready   = (state_q == S_RESP) && (op_q == OP_PUSH);
    assign st_empty   = empty_q;
    assign st_full    = full_q;
    assign rd_hit     = res_hit_q;
    assign rd_data    = res_data_q;
    assign wr_taken   = res_hit_q;

endmodule

// File: rtl/srb_port.sv
// Top of the shared-memory byte ring port: sequencer, header registers
// and single-transaction memory master.
// Assumes ADDR_W is at least DATA_W and the remote mask has the form 2^k-1.
module srb_port
    import srb_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              init_valid,
    output logic              init_ready,
    input  logic              st_valid,
    output logic              st_ready,
    output logic              st_empty,
    output logic              st_full,
    input  logic              rd_valid,
    input  logic              rd_block,
    output logic              rd_ready,
    output logic              rd_hit,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_valid,
    input  logic              wr_block,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              wr_taken,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic                          go, go_we, done, ld_mask;
    logic [ADDR_W-1:0]             go_addr;
    logic [DATA_W-1:0]             go_wdata;
    logic [N_IDX-1:0]              ld_idx, adv_idx;
    logic [N_IDX-1:0][DATA_W-1:0]  idx_q, idx_nxt;

    srb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_base   (cfg_base),
        .init_valid (init_valid),
        .init_ready (init_ready),
        .st_valid   (st_valid),
        .st_ready   (st_ready),
        .st_empty   (st_empty),
        .st_full    (st_full),
        .rd_valid   (rd_valid),
        .rd_block   (rd_block),
        .rd_ready   (rd_ready),
        .rd_hit     (rd_hit),
        .rd_data    (rd_data),
        .wr_valid   (wr_valid),
        .wr_block   (wr_block),
        .wr_data    (wr_data),
        .wr_ready   (wr_ready),
        .wr_taken   (wr_taken),
        .go         (go),
        .go_we      (go_we),
        .go_addr    (go_addr),
        .go_wdata   (go_wdata),
        .done       (done),
        .rdata      (mem_rdata),
        .ld_mask    (ld_mask),
        .ld_idx     (ld_idx),
        .adv_idx    (adv_idx),
        .idx_q      (idx_q),
        .idx_nxt    (idx_nxt)
    );

    srb_ring_regs #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_mask (ld_mask),
        .ld_idx  (ld_idx),
        .adv_idx (adv_idx),
        .ld_val  (mem_rdata),
        .idx_q   (idx_q),
        .idx_nxt (idx_nxt)
    );

    srb_mem_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .go_we     (go_we),
        .go_addr   (go_addr),
        .go_wdata  (go_wdata),
        .done      (done),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack)
    );

endmodule

// File: rtl/srb_port_chk.sv
// Protocol checker for srb_port, attached by bind. Observes ports only.
// Assumes cfg_base is stable while init is pending.
module srb_port_chk #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cfg_base,
    input logic              init_valid,
    input logic              init_ready,
    input logic              st_valid,
    input logic              st_ready,
    input logic              st_empty,
    input logic              st_full,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic              rd_hit,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic              wr_taken,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack
);

    logic en_seen;
    logic any_ready;

    assign any_ready = init_ready || st_ready || rd_ready || wr_ready;

    // Track from the ports whether the last init enabled the port
    always_ff @(posedge clk) begin
        if (!rst_n)          en_seen <= 1'b0;
        else if (init_ready) en_seen <= (cfg_base != '0);
    end

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    p_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> !mem_req);

    p_one_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({init_ready, st_ready, rd_ready, wr_ready}));

    p_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        any_ready |=> !any_ready);

    p_init_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        init_ready |-> $past(init_valid));

    p_st_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        st_ready |-> $past(st_valid));

    p_rd_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> $past(rd_valid));

    p_wr_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> $past(wr_valid));

    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_seen && !init_valid |-> !mem_req);

    p_stat_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_ready && !en_seen |-> st_empty && !st_full);

    p_pop_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready && !en_seen |-> !rd_hit);

    p_push_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready && !en_seen |-> !wr_taken);

endmodule

bind srb_port srb_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_srb_port.sv
`timescale 1ns/1ps
module sim_srb_port;

    localparam int AW = 8;
    localparam int DW = 8;
    localparam int LOGN = 4096;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cfg_base = '0;
    logic          init_valid = 1'b0, st_valid = 1'b0, rd_valid = 1'b0, wr_valid = 1'b0;
    logic          rd_block = 1'b0, wr_block = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          init_ready, st_ready, st_empty, st_full;
    logic          rd_ready, rd_hit, wr_ready, wr_taken;
    logic [DW-1:0] rd_data;
    logic          mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    srb_port #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base),
        .init_valid(init_valid), .init_ready(init_ready),
        .st_valid(st_valid), .st_ready(st_ready), .st_empty(st_empty), .st_full(st_full),
        .rd_valid(rd_valid), .rd_block(rd_block), .rd_ready(rd_ready), .rd_hit(rd_hit), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_block(wr_block), .wr_data(wr_data), .wr_ready(wr_ready), .wr_taken(wr_taken),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Memory model with programmable wait states and a transaction log
    logic [DW-1:0] mem [0:255];
    logic [AW-1:0] log_a [0:LOGN-1];
    logic          log_w [0:LOGN-1];
    logic [DW-1:0] log_d [0:LOGN-1];
    int            log_n = 0;
    int            lat = 0;
    int            wcnt = 0;

    assign mem_ack   = mem_req && (wcnt == lat);
    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_req && !mem_ack) wcnt <= wcnt + 1;
        else wcnt <= 0;
        if (mem_req && mem_ack) begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            log_a[log_n % LOGN] <= mem_addr;
            log_w[log_n % LOGN] <= mem_we;
            log_d[log_n % LOGN] <= mem_we ? mem_wdata : mem_rdata;
            log_n <= log_n + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_log(input string tag, input int n, input int a, input int w, input int d);
        chk({tag, " addr"}, int'(log_a[n % LOGN]), a);
        chk({tag, " dir"},  int'(log_w[n % LOGN]), w);
        if (d >= 0) chk({tag, " data"}, int'(log_d[n % LOGN]), d);
    endtask

    task automatic poke(input int a, input int v);
        @(negedge clk);
        mem[a[7:0]] <= v[7:0];
    endtask

    task automatic do_init(input int b);
        @(negedge clk);
        cfg_base   = b[7:0];
        init_valid = 1'b1;
        do @(negedge clk); while (!init_ready);
        init_valid = 1'b0;
    endtask

    task automatic do_stat(output int e, output int f);
        @(negedge clk);
        st_valid = 1'b1;
        do @(negedge clk); while (!st_ready);
        e = int'(st_empty);
        f = int'(st_full);
        st_valid = 1'b0;
    endtask

    task automatic do_pop(input bit blk, output int hit, output int d);
        @(negedge clk);
        rd_valid = 1'b1;
        rd_block = blk;
        do @(negedge clk); while (!rd_ready);
        hit = int'(rd_hit);
        d   = int'(rd_data);
        rd_valid = 1'b0;
    endtask

    task automatic do_push(input bit blk, input int d, output int tk);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_block = blk;
        wr_data  = d[7:0];
        do @(negedge clk); while (!wr_ready);
        tk = int'(wr_taken);
        wr_valid = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=1 exp=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int e, f, hit, d, tk, n0, base, msk, bw, br, got;
        int stash [0:7];
        for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset mem_req", int'(mem_req), 0);
        chk("R12 reset readies", int'({init_ready, st_ready, rd_ready, wr_ready}), 0);

        // R2: disabled after reset
        n0 = log_n;
        do_stat(e, f);
        chk("R2 status empty off", e, 1);
        chk("R2 status full off", f, 0);
        do_pop(1'b1, hit, d);
        chk("R2 blocking pop off", hit, 0);
        do_push(1'b1, 8'h11, tk);
        chk("R2 blocking push off", tk, 0);
        chk("R2 no traffic", log_n - n0, 0);

        // R1: header load
        base = 8'h40; msk = 7; bw = 3; br = 3;
        poke(base - 3, msk); poke(base - 2, bw); poke(base - 1, br);
        n0 = log_n;
        do_init(base);
        chk("R1 init count", log_n - n0, 3);
        chk_log("R1 mask", n0,     base - 3, 0, msk);
        chk_log("R1 wi",   n0 + 1, base - 2, 0, bw);
        chk_log("R1 ri",   n0 + 2, base - 1, 0, br);

        // R3/R4: status after init
        n0 = log_n;
        do_stat(e, f);
        chk("R3 empty after init", e, 1);
        chk("R4 full after init", f, 0);
        chk_log("R3 fresh wi read", n0, base - 2, 0, -1);
        chk_log("R4 fresh ri read", n0 + 1, base - 1, 0, -1);

        // Sweep: fill and drain three times under different wait states
        for (int rnd = 0; rnd < 3; rnd++) begin
            lat = rnd;
            for (int k = 0; k < 8; k++) begin
                int dv;
                dv = (rnd * 37 + k * 5 + 1) & 255;
                n0 = log_n;
                do_push(1'b0, dv, tk);
                if (((bw + 1) & msk) == br) begin
                    chk("R8 full push refused", tk, 0);
                    chk("R8 only check read", log_n - n0, 1);
                end else begin
                    chk("R6 push taken", tk, 1);
                    chk_log("R6 check", n0, base - 1, 0, -1);
                    chk_log("R6 data", n0 + 1, base + bw, 1, dv);
                    chk_log("R6 index", n0 + 2, base - 2, 1, (bw + 1) & msk);
                    stash[bw] = dv;
                    bw = (bw + 1) & msk;
                end
            end
            do_stat(e, f);
            chk("R4 full after fill", f, 1);
            chk("R3 not empty after fill", e, 0);
            for (int k = 0; k < 8; k++) begin
                n0 = log_n;
                do_pop(1'b0, hit, d);
                if (bw == br) begin
                    chk("R7 empty pop refused", hit, 0);
                    chk("R7 only check read", log_n - n0, 1);
                end else begin
                    chk("R5 pop hit", hit, 1);
                    chk("R5 pop data", d, stash[br]);
                    chk_log("R5 check", n0, base - 2, 0, -1);
                    chk_log("R5 data", n0 + 1, base + br, 0, stash[br]);
                    chk_log("R5 index", n0 + 2, base - 1, 1, (br + 1) & msk);
                    br = (br + 1) & msk;
                end
            end
            do_stat(e, f);
            chk("R3 empty after drain", e, 1);
            chk("R4 not full after drain", f, 0);
            chk("R5 remote ri", int'(mem[base - 1]), br);
            chk("R6 remote wi", int'(mem[base - 2]), bw);
        end
        lat = 1;

        // R9: blocking pop waits for a partner write
        n0 = log_n;
        got = 0;
        fork
            begin
                do_pop(1'b1, hit, d);
                got = 1;
            end
            begin
                int polls, nonpoll;
                repeat (40) @(negedge clk);
                chk("R9 no answer while empty", got, 0);
                polls = 0; nonpoll = 0;
                for (int i = n0; i < log_n; i++) begin
                    if (log_a[i % LOGN] == AW'(base - 2) && !log_w[i % LOGN]) polls++;
                    else nonpoll++;
                end
                chk("R9 repeated polls", int'(polls >= 2), 1);
                chk("R9 only polls", nonpoll, 0);
                poke(base + br, 8'hA5);
                poke(base - 2, (br + 1) & msk);
            end
        join
        chk("R9 pop hit", hit, 1);
        chk("R9 pop data", d, 8'hA5);
        chk("R9 remote ri", int'(mem[base - 1]), (br + 1) & msk);

        // R10: blocking push waits for a partner read
        poke(base - 3, msk); poke(base - 2, 0); poke(base - 1, 0);
        do_init(base);
        for (int k = 0; k < 7; k++) begin
            do_push(1'b0, 8'h20 + k, tk);
        end
        chk("R10 ring filled", tk, 1);
        n0 = log_n;
        got = 0;
        fork
            begin
                do_push(1'b1, 8'h5A, tk);
                got = 1;
            end
            begin
                int nonpoll;
                repeat (40) @(negedge clk);
                chk("R10 no answer while full", got, 0);
                nonpoll = 0;
                for (int i = n0; i < log_n; i++)
                    if (log_a[i % LOGN] != AW'(base - 1) || log_w[i % LOGN]) nonpoll++;
                chk("R10 only polls", nonpoll, 0);
                chk("R10 polled", int'(log_n - n0 >= 2), 1);
                poke(base - 1, 1);
            end
        join
        chk("R10 push taken", tk, 1);
        chk("R10 data stored", int'(mem[base + 7]), 8'h5A);
        chk("R10 remote wi", int'(mem[base - 2]), 0);

        // R12: status wins over a simultaneous pop
        poke(base - 3, msk); poke(base - 2, 2); poke(base - 1, 0);
        do_init(base);
        @(negedge clk);
        st_valid = 1'b1; rd_valid = 1'b1; rd_block = 1'b0;
        do @(negedge clk); while (!st_ready && !rd_ready);
        chk("R12 status first", int'(st_ready), 1);
        chk("R12 pop waits", int'(rd_ready), 0);
        st_valid = 1'b0;
        do @(negedge clk); while (!rd_ready);
        chk("R12 pop served after", int'(rd_hit), 1);
        rd_valid = 1'b0;

        // R13: header wraps below address 0
        poke(8'hFE, 3); poke(8'hFF, 0); poke(8'h00, 0);
        n0 = log_n;
        do_init(1);
        chk_log("R13 mask addr", n0,     8'hFE, 0, 3);
        chk_log("R13 wi addr",   n0 + 1, 8'hFF, 0, 0);
        chk_log("R13 ri addr",   n0 + 2, 8'h00, 0, 0);
        n0 = log_n;
        do_push(1'b0, 8'h77, tk);
        chk("R13 push taken", tk, 1);
        chk_log("R13 push data", n0 + 1, 8'h01, 1, 8'h77);
        chk_log("R13 push wi", n0 + 2, 8'hFF, 1, 1);
        do_pop(1'b0, hit, d);
        chk("R13 pop data", d, 8'h77);
        chk("R13 remote ri", int'(mem[0]), 1);

        // R2: disabling again with a zero base
        n0 = log_n;
        do_init(0);
        do_stat(e, f);
        chk("R2 re-disabled empty", e, 1);
        chk("R2 re-disabled full", f, 0);
        do_pop(1'b0, hit, d);
        chk("R2 re-disabled pop", hit, 0);
        do_push(1'b0, 8'h33, tk);
        chk("R2 re-disabled push", tk, 0);
        chk("R2 re-disabled no traffic", log_n - n0, 0);

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule